// File: doc/BRIEF.md
# Grouped Pin Change Interrupt Controller

This block watches 27 input pins and turns any change of level on a selected pin into an interrupt request. The pins are gathered into four groups of unequal size. Every group has its own pin-select mask, its own enable bit and its own request line. A change of level on a selected pin, rising or falling, sets a pending bit for that pin's group. That bit stays set until the group's acknowledge arrives or software clears it.

The pins arrive from outside the clock domain. Each pin passes through a two-flop synchronizer. A change is found by comparing each synchronized value with its value one cycle earlier. A group's request line is high while its pending bit, its enable bit and the global interrupt enable are all one. Software reaches the enables, the four masks and the pending bits through a small register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `pin_change_irq_ctrl`

## Requirements
- R1: Pins belong to groups as follows. Group 0 holds pins 0..7, group 1 holds pins 8..14, group 2 holds pins 16..23 and group 3 holds pins 24..26. Bit i of group g's mask selects pin (8*g + i). Pin 15 belongs to no group, and a change on it sets no pending bit.
- R2: A rising or falling change on a selected pin, driven between two clock edges, sets its group's pending bit on the third rising edge that follows. The bit is still clear after the second edge.
- R3: A change on a pin whose mask bit is zero leaves every pending bit unchanged.
- R4: irq_o[g] is high exactly when pending bit g, enable bit g and gie_i are all one.
- R5: The control register is at address 0, with bits 3:0 enabling groups 3..0. Bits 7:4 read as zero, and writes to them are ignored.
- R6: The pending register is at address 5, with bits 3:0 holding groups 3..0 and bits 7:4 reading as zero. Writing a one to a bit clears it on that edge. Writing a zero leaves it unchanged.
- R7: Holding ack_i[g] high across a clock edge clears pending bit g and no other bit.
- R8: A change that is detected in the same cycle as an acknowledge, or as a clearing write, leaves the pending bit set.
- R9: The masks for groups 0..3 are at addresses 1..4. Bit 7 of group 1's mask and bits 7:3 of group 3's mask read as zero and ignore writes.
- R10: After reset, every register reads zero and every request line is low.
- R11: A pending bit is set even while its group is disabled. Setting the enable bit afterwards raises the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pins_i | input | 27 | Asynchronous monitored pins |
| gie_i | input | 1 | Global interrupt enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ack_i | input | 4 | Per-group acknowledge |
| irq_o | output | 4 | Per-group request lines |

## Verification
The bench drives one pin at each group boundary, pin 15 and the highest pin, and confirms that only the expected group's bit sets. A design with an off-by-one in the group slicing would flag the wrong group, or would flag one on pin 15. It checks that the pending bit is still clear after the second edge and set after the third. A synchronizer with too few or too many stages would miss one of those two points. It lines up a fresh change with an acknowledge, and separately with a clearing write, in the same cycle. A design that gives clearing the priority would lose that event. Writes of all ones to the control register and the short masks catch reserved bits that retain their values.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
    localparam int NUM_GROUPS   = 4;
    localparam int REG_W        = 8;
    localparam int NUM_PINS     = 27;
    localparam int ADDR_W       = 3;
    localparam int GROUP_STRIDE = REG_W;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL  = 3'd0,
        ADDR_MASK0 = 3'd1,
        ADDR_MASK1 = 3'd2,
        ADDR_MASK2 = 3'd3,
        ADDR_MASK3 = 3'd4,
        ADDR_FLAG  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } reg_req_t;

    function automatic int grp_width(input int g);
        case (g)
            0:       return 8;
            1:       return 7;
            2:       return 8;
            default: return 3;
        endcase
    endfunction

    function automatic int grp_base(input int g);
        return g * GROUP_STRIDE;
    endfunction

    function automatic logic [NUM_PINS-1:0] covered_pins();
        logic [NUM_PINS-1:0] m;
        m = '0;
        for (int g = 0; g < NUM_GROUPS; g++)
            for (int i = 0; i < grp_width(g); i++)
                m[grp_base(g) + i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/pcx_sync.sv
module pcx_sync
    import pcx_pkg::*;
#(
    parameter int W = NUM_PINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] chg_o
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign chg_o = sync_q ^ prev_q;

    // R2: a reported change is a real level difference one stage apart
    p_chg_from_level_r2: assert property (@(posedge clk) disable iff (rst)
        |chg_o |=> (prev_q != $past(prev_q)));
endmodule

// File: rtl/pcx_regs.sv
module pcx_regs
    import pcx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  reg_req_t              req_i,
    input  logic [NUM_GROUPS-1:0] flags_i,
    output logic [NUM_GROUPS-1:0] en_o,
    output logic [NUM_PINS-1:0]   mask_pin_o,
    output logic [NUM_GROUPS-1:0] flag_clr_o,
    output logic [REG_W-1:0]      rdata_o
);
    localparam logic [NUM_PINS-1:0] COVERED = covered_pins();

    logic [NUM_GROUPS-1:0] en_q;
    logic [NUM_PINS-1:0]   mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mask_q <= '0;
        end else if (req_i.wr) begin
            if (req_i.addr == ADDR_CTRL)
                en_q <= req_i.data[NUM_GROUPS-1:0];
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (req_i.addr == ADDR_W'(int'(ADDR_MASK0) + g)) begin
                    for (int i = 0; i < grp_width(g); i++)
                        mask_q[grp_base(g) + i] <= req_i.data[i];
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (req_i.addr == ADDR_CTRL)
            rdata_o[NUM_GROUPS-1:0] = en_q;
        else if (req_i.addr == ADDR_FLAG)
            rdata_o[NUM_GROUPS-1:0] = flags_i;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (req_i.addr == ADDR_W'(int'(ADDR_MASK0) + g)) begin
                for (int i = 0; i < grp_width(g); i++)
                    rdata_o[i] = mask_q[grp_base(g) + i];
            end
        end
    end

    assign en_o       = en_q;
    assign mask_pin_o = mask_q & COVERED;
    assign flag_clr_o = (req_i.wr && req_i.addr == ADDR_FLAG) ?
                        req_i.data[NUM_GROUPS-1:0] : '0;

    // R5: control write lands in the enables, upper data bits dropped
    p_ctrl_write_r5: assert property (@(posedge clk) disable iff (rst)
        (req_i.wr && req_i.addr == ADDR_CTRL) |=> (en_o == $past(req_i.data[NUM_GROUPS-1:0])));
    // R9: pin positions outside every group never hold a mask bit
    p_mask_gap_r9: assert property (@(posedge clk) disable iff (rst)
        ((mask_q & ~COVERED) == '0));
    // R10: state is zero on the cycle after reset
    p_reset_zero_r10: assert property (@(posedge clk)
        $past(rst) |-> (en_q == '0 && mask_q == '0));
endmodule

// File: rtl/pcx_group.sv
module pcx_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] chg_i,
    input  logic [W-1:0] mask_i,
    input  logic         ack_i,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         gie_i,
    output logic         flag_o,
    output logic         irq_o
);
    logic hit;
    logic flag_q;

    assign hit = |(chg_i & mask_i);

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (ack_i || clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & en_i & gie_i;

    // R2: a selected change always leaves the flag set
    p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);
    // R3: the flag never rises without a selected change
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
        !hit |=> !$rose(flag_q));
    // R7: acknowledge with no new change clears the flag
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !hit) |=> !flag_q);
    // R8: a change wins over a coincident clear
    p_change_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && (ack_i || clr_i)) |=> flag_q);
endmodule

// File: rtl/pin_change_irq_ctrl.sv
module pin_change_irq_ctrl
    import pcx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PINS-1:0]   pins_i,
    input  logic                  gie_i,
    input  logic                  reg_wr_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [REG_W-1:0]      reg_wdata_i,
    output logic [REG_W-1:0]      reg_rdata_o,
    input  logic [NUM_GROUPS-1:0] ack_i,
    output logic [NUM_GROUPS-1:0] irq_o
);
    localparam logic [NUM_PINS-1:0] COVERED = covered_pins();

    reg_req_t              req;
    logic [NUM_PINS-1:0]   chg;
    logic [NUM_PINS-1:0]   mask_pin;
    logic [NUM_GROUPS-1:0] en, flags, flag_clr;
    logic                  unused_gap_bits;

    assign req = '{wr: reg_wr_i, addr: reg_addr_i, data: reg_wdata_i};

    pcx_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(pins_i),
        .chg_o  (chg)
    );

    pcx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .flags_i   (flags),
        .en_o      (en),
        .mask_pin_o(mask_pin),
        .flag_clr_o(flag_clr),
        .rdata_o   (reg_rdata_o)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int GW = grp_width(g);
        localparam int GB = grp_base(g);
        pcx_group #(.W(GW)) u_group (
            .clk   (clk),
            .rst   (rst),
            .chg_i (chg[GB +: GW]),
            .mask_i(mask_pin[GB +: GW]),
            .ack_i (ack_i[g]),
            .clr_i (flag_clr[g]),
            .en_i  (en[g]),
            .gie_i (gie_i),
            .flag_o(flags[g]),
            .irq_o (irq_o[g])
        );
    end

    assign unused_gap_bits = ^{chg & ~COVERED, mask_pin & ~COVERED};

    // R4: a request is never raised while the global enable is low
    p_irq_needs_gie_r4: assert property (@(posedge clk) disable iff (rst)
        !gie_i |-> (irq_o == '0));
endmodule

// File: tb/pin_change_irq_ctrl_bench.sv
module pin_change_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [26:0] pins = '0;
    logic       gie = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] ack = '0;
    logic [3:0] irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pin_change_irq_ctrl u_pin_change_irq_ctrl (
        .clk(clk), .rst(rst), .pins_i(pins), .gie_i(gie),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .ack_i(ack), .irq_o(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic flip_pin(input int p);
        @(negedge clk);
        pins[p] = ~pins[p];
        repeat (3) @(posedge clk);
    endtask

    task automatic expect_flags(input logic [3:0] exp, input string req);
        logic [7:0] d;
        reg_rd(3'd5, d);
        check(d == {4'h0, exp}, req, d, {4'h0, exp});
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 6; a++) begin
            reg_rd(a[2:0], d);
            check(d == 8'h00, "R10 reg", d, 0);
        end
        check(irq == 4'h0, "R10 irq", irq, 0);
    endtask

    task automatic t_reserved;
        logic [7:0] d;
        reg_wr(3'd0, 8'hFF); reg_rd(3'd0, d);
        check(d == 8'h0F, "R5 ctrl reserved", d, 8'h0F);
        reg_wr(3'd1, 8'hFF); reg_rd(3'd1, d);
        check(d == 8'hFF, "R9 mask0 full", d, 8'hFF);
        reg_wr(3'd2, 8'hFF); reg_rd(3'd2, d);
        check(d == 8'h7F, "R9 mask1 short", d, 8'h7F);
        reg_wr(3'd4, 8'hFF); reg_rd(3'd4, d);
        check(d == 8'h07, "R9 mask3 short", d, 8'h07);
        reg_wr(3'd5, 8'hF0); reg_rd(3'd5, d);
        check(d == 8'h00, "R6 flag upper", d, 0);
        for (int a = 1; a < 5; a++) reg_wr(a[2:0], 8'h00);
    endtask

    task automatic t_latency_and_clear;
        logic [7:0] d;
        reg_wr(3'd1, 8'h01);
        gie = 1'b1;
        @(negedge clk);
        pins[0] = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(irq[0] == 1'b0, "R2 not yet after two edges", irq, 0);
        @(posedge clk);
        expect_flags(4'h1, "R2 rise sets flag");
        check(irq == 4'h1, "R4 irq with en and gie", irq, 4'h1);
        reg_wr(3'd5, 8'h00);
        expect_flags(4'h1, "R6 write zero keeps");
        reg_wr(3'd5, 8'h01);
        expect_flags(4'h0, "R6 write one clears");
        flip_pin(0);
        expect_flags(4'h1, "R2 fall sets flag");
        reg_wr(3'd5, 8'h0F);
        flip_pin(1);
        expect_flags(4'h0, "R3 masked pin ignored");
        reg_rd(3'd1, d);
        check(d == 8'h01, "R3 mask kept", d, 8'h01);
        reg_wr(3'd1, 8'h00);
    endtask

    task automatic t_mapping;
        int plist [7] = '{7, 8, 14, 16, 23, 24, 26};
        for (int k = 0; k < 7; k++) begin
            int p = plist[k];
            int g = p / 8;
            reg_wr(3'(g + 1), 8'(1 << (p % 8)));
            flip_pin(p);
            expect_flags(4'(1 << g), $sformatf("R1 pin %0d", p));
            reg_wr(3'(g + 1), 8'h00);
            reg_wr(3'd5, 8'h0F);
        end
        for (int a = 1; a < 5; a++) reg_wr(a[2:0], 8'hFF);
        flip_pin(15);
        expect_flags(4'h0, "R1 pin 15 unmapped");
        for (int a = 1; a < 5; a++) reg_wr(a[2:0], 8'h00);
    endtask

    task automatic t_gating;
        reg_wr(3'd0, 8'h00);
        reg_wr(3'd3, 8'h10);
        flip_pin(20);
        expect_flags(4'h4, "R11 flag while disabled");
        check(irq == 4'h0, "R4 disabled no irq", irq, 0);
        reg_wr(3'd0, 8'h04);
        #1;
        check(irq == 4'h4, "R11 enable raises irq", irq, 4'h4);
        gie = 1'b0;
        #1;
        check(irq == 4'h0, "R4 gie low", irq, 0);
        gie = 1'b1;
        reg_wr(3'd0, 8'h0F);
        reg_wr(3'd3, 8'h00);
    endtask

    task automatic t_ack;
        reg_wr(3'd1, 8'h02);
        reg_wr(3'd4, 8'h01);
        flip_pin(1);
        flip_pin(24);
        expect_flags(4'hD, "R7 setup");
        @(negedge clk); ack = 4'h1;
        @(negedge clk); ack = 4'h0;
        expect_flags(4'hC, "R7 ack clears own group only");
        reg_wr(3'd5, 8'h0F);
    endtask

    task automatic t_collision;
        flip_pin(1);
        expect_flags(4'h1, "R8 setup");
        @(negedge clk);
        pins[1] = ~pins[1];
        repeat (2) @(posedge clk);
        @(negedge clk); ack = 4'h1;
        @(negedge clk); ack = 4'h0;
        expect_flags(4'h1, "R8 change beats ack");
        @(negedge clk);
        pins[1] = ~pins[1];
        repeat (2) @(posedge clk);
        @(negedge clk); wr = 1'b1; addr = 3'd5; wdata = 8'h01;
        @(negedge clk); wr = 1'b0;
        expect_flags(4'h1, "R8 change beats clear write");
        reg_wr(3'd5, 8'h0F);
        expect_flags(4'h0, "R8 cleanup");
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reserved();
        reg_wr(3'd0, 8'h0F);
        t_latency_and_clear();
        t_mapping();
        t_gating();
        t_ack();
        t_collision();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule